// File: doc/BRIEF.md
# Two-wire bus master controller

This block is the master side of a two-wire, open-drain serial bus in the I2C style. A processor sets a start-request control bit. The block waits until its bus monitor reports the bus as free, then issues a start condition and claims the bus. It then stalls the bus by holding the clock line low and reports that it needs service. When the processor writes an address byte (a 7-bit target address followed by one direction bit, where 1 means read), the block shifts the byte out and captures the target's acknowledge. It then either stops and waits, or, for a read, fetches the first data byte on its own.

Both lines are watched for interference by other devices for the whole time the block drives the bus. On any conflict the transfer is abandoned, both lines are let go and a bus-error flag is raised. An address-only stall mode freezes the bus after a clean address phase, so the processor can check the target's presence without moving any data. The status flags are cleared by writing 1 to them. When interrupts are enabled, a single interrupt line reflects them. The SCL period comes from a half-period count in system clock cycles.

Top module: `twi_master_ctl`

## Requirements
- R1: The bus-busy flag (STAT bit 5) goes to 1 after a start condition from any device (SDA falling while SCL is high) and to 0 after a stop condition (SDA rising while SCL is high). A start request (CTRL bit 0) issues a start condition only while this flag is 0; SDA is not driven as long as the bus is busy.
- R2: After a start without conflict, SCL is held low, the master flag (STAT bit 4) and the service flag (STAT bit 1) are set, and the start-request bit reads back as 0.
- R3: If SCL is low during acquisition (driven by another device before this block pulls it), the bus-error flag (STAT bit 0) is set and the master flag stays 0.
- R4: A write to DATA (address 2) while master and in need of service sends that byte MSB first, one bit per SCL pulse. Bit 0 is the direction (1 = read).
- R5: The SDA level sampled in the ninth clock pulse of the address byte is stored in the NACK flag (STAT bit 2): 1 means not acknowledged.
- R6: If SCL is found low while released, or SDA is found low while this block releases it for an address bit, the transfer aborts. The bus-error flag is set, the master flag is cleared, and SCL and SDA are both released.
- R7: With the address-only stall bit (CTRL bit 3) set and the address acknowledged, the stall flag (STAT bit 3) is set and SCL stays low with no further clock pulses.
- R8: For a write-direction address that is acknowledged, with stall mode off, the service flag is set and SCL stays low.
- R9: For a read-direction address that is acknowledged, with stall mode off, one data byte is clocked in automatically and can be read from DATA, after which the service flag is set. The block answers that byte with NACK (SDA released) when the reply-NACK bit (CTRL bit 2) is 1, and with ACK (SDA low) when it is 0.
- R10: The interrupt output is 1 when the interrupt-enable bit (CTRL bit 1) is 1 and any of bus error, service, NACK or stall is set; it is 0 when interrupts are disabled.
- R11: Writing 1 to a bit among STAT bits 0 to 3 clears that flag. Writing 0 leaves it unchanged.
- R12: A DATA write is ignored unless the block is master, needs service and has not yet sent an address in this session. An ignored write causes no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | AW | Register select: 0 CTRL, 1 STAT, 2 DATA |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for reg_addr, one cycle later |
| irq | output | 1 | Interrupt request |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| sda_drive_low | output | 1 | 1 pulls SDA low |

## Verification
The hardest situations to reach from the ports are conflicts in the middle of a byte, because they depend on where the block is within an SCL pulse. The bench waits for a rising edge of the bus SCL level and pulls SCL low at once. For an SDA conflict it pulls SDA low ahead of an address whose first bit is 1. A bus model that counts SCL edges plays the target. The bench then sweeps address patterns, target ACK or NACK, stall mode, reply-NACK and interrupt enable, and checks the address bits the model received, the flags, the received byte and the master's acknowledge against values worked out from those inputs.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned R_CTRL = 0;
  localparam int unsigned R_STAT = 1;
  localparam int unsigned R_DATA = 2;

  typedef enum logic [2:0] {
    S_IDLE, S_ACQ, S_HOLD, S_BLO, S_BHI, S_ALO, S_AHI
  } seq_st_e;
endpackage

// File: rtl/twi_halfcnt.sv
module twi_halfcnt #(
  parameter int unsigned HALF_CYC = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int unsigned CW = $clog2(HALF_CYC) + 1;
  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(HALF_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (!tick) cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/twi_busmon.sv
module twi_busmon (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic busy
);
  logic scl_p, sda_p, start_c, stop_c;

  assign start_c = scl_p & scl_in & sda_p & ~sda_in;
  assign stop_c  = scl_p & scl_in & ~sda_p & sda_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
      busy  <= 1'b0;
    end else begin
      scl_p <= scl_in;
      sda_p <= sda_in;
      if (start_c) busy <= 1'b1;
      else if (stop_c) busy <= 1'b0;
    end
  end

  p_busy_set_r1: assert property (@(posedge clk) disable iff (rst) start_c |=> busy);
  p_busy_clr_r1: assert property (@(posedge clk) disable iff (rst) stop_c |=> !busy);
endmodule

// File: rtl/twi_seq.sv
module twi_seq
  import twi_pkg::*;
#(
  parameter int unsigned HALF_CYC = 250
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              busy,
  input  logic              nack_ctl,
  input  logic              stall_en,
  input  logic              wr_go,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_low,
  output logic              sda_low,
  output logic              ev_win,
  output logic              ev_err,
  output logic              ev_svc,
  output logic              ev_nack,
  output logic              ev_stall,
  output logic              ev_rx_end,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int unsigned BC_W = $clog2(BYTE_W);

  seq_st_e st, st_nx;
  logic scl_nx, sda_nx, rxm, rxm_nx, rd, rd_nx, tick;
  logic [BYTE_W-1:0] sh, sh_nx;
  logic [BC_W-1:0] bc, bc_nx;

  twi_halfcnt #(.HALF_CYC(HALF_CYC)) u_half (
    .clk(clk), .rst(rst), .restart(st_nx != st), .tick(tick)
  );

  assign rx_byte = sh;

  always_comb begin
    st_nx = st; scl_nx = scl_low; sda_nx = sda_low;
    sh_nx = sh; bc_nx = bc; rxm_nx = rxm; rd_nx = rd;
    ev_win = 1'b0; ev_err = 1'b0; ev_svc = 1'b0;
    ev_nack = 1'b0; ev_stall = 1'b0; ev_rx_end = 1'b0;
    case (st)
      S_IDLE: begin
        scl_nx = 1'b0; sda_nx = 1'b0;
        if (go && !busy) begin st_nx = S_ACQ; sda_nx = 1'b1; end
      end
      S_ACQ: begin
        if (!scl_in) ev_err = 1'b1;
        else if (tick) begin st_nx = S_HOLD; scl_nx = 1'b1; ev_win = 1'b1; ev_svc = 1'b1; end
      end
      S_HOLD: begin
        if (wr_go) begin
          sh_nx = wr_byte; rd_nx = wr_byte[0]; rxm_nx = 1'b0; bc_nx = '0;
          sda_nx = !wr_byte[BYTE_W-1]; st_nx = S_BLO;
        end
      end
      S_BLO: begin
        if (tick) begin scl_nx = 1'b0; st_nx = S_BHI; end
      end
      S_BHI: begin
        if (!scl_in) ev_err = 1'b1;
        else if (!rxm && !sda_low && !sda_in) ev_err = 1'b1;
        else if (tick) begin
          sh_nx  = {sh[BYTE_W-2:0], sda_in};
          scl_nx = 1'b1;
          bc_nx  = bc + BC_W'(1);
          if (bc == BC_W'(BYTE_W - 1)) begin
            st_nx  = S_ALO;
            sda_nx = rxm ? !nack_ctl : 1'b0;
          end else begin
            st_nx  = S_BLO;
            sda_nx = rxm ? 1'b0 : !sh[BYTE_W-2];
          end
        end
      end
      S_ALO: begin
        if (tick) begin scl_nx = 1'b0; st_nx = S_AHI; end
      end
      S_AHI: begin
        if (!scl_in) ev_err = 1'b1;
        else if (tick) begin
          scl_nx = 1'b1;
          sda_nx = 1'b0;
          st_nx  = S_HOLD;
          if (rxm) begin
            ev_rx_end = 1'b1;
            ev_svc    = 1'b1;
          end else begin
            ev_nack  = sda_in;
            ev_stall = !sda_in && stall_en;
            ev_svc   = !sda_in && !stall_en && !rd;
            if (!sda_in && !stall_en && rd) begin
              rxm_nx = 1'b1; bc_nx = '0; st_nx = S_BLO;
            end
          end
        end
      end
      default: st_nx = S_IDLE;
    endcase
    if (ev_err) begin
      st_nx = S_IDLE; scl_nx = 1'b0; sda_nx = 1'b0;
      ev_win = 1'b0; ev_svc = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; scl_low <= 1'b0; sda_low <= 1'b0;
      sh <= '0; bc <= '0; rxm <= 1'b0; rd <= 1'b0;
    end else begin
      st <= st_nx; scl_low <= scl_nx; sda_low <= sda_nx;
      sh <= sh_nx; bc <= bc_nx; rxm <= rxm_nx; rd <= rd_nx;
    end
  end

  p_scl_conflict_r6: assert property (@(posedge clk) disable iff (rst)
    ((st == S_BHI || st == S_AHI || st == S_ACQ) && !scl_in) |=> (st == S_IDLE && !scl_low));
  p_addr_msb_r4: assert property (@(posedge clk) disable iff (rst)
    (st == S_HOLD && wr_go) |=> (sda_low == !$past(wr_byte[BYTE_W-1])));
endmodule

// File: rtl/twi_master_ctl.sv
module twi_master_ctl
  import twi_pkg::*;
#(
  parameter int unsigned HALF_CYC = 250,
  parameter int unsigned AW       = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     reg_addr,
  input  logic              reg_we,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              irq,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_drive_low,
  output logic              sda_drive_low
);
  logic busy;
  logic ctrl_go, ctrl_ien, ctrl_rxnak, ctrl_stall;
  logic err_q, svc_q, nack_q, stl_q, master_q, addr_sent_q;
  logic [BYTE_W-1:0] rx_q, rx_byte;
  logic ev_win, ev_err, ev_svc, ev_nack, ev_stall, ev_rx_end;
  logic sel_ctrl, sel_stat, sel_data, wr_go;
  logic [3:0] w1c;

  assign sel_ctrl = reg_addr == AW'(R_CTRL);
  assign sel_stat = reg_addr == AW'(R_STAT);
  assign sel_data = reg_addr == AW'(R_DATA);
  assign wr_go    = reg_we && sel_data && master_q && svc_q && !addr_sent_q;
  assign w1c      = (reg_we && sel_stat) ? reg_wdata[3:0] : 4'b0000;

  twi_busmon u_mon (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .busy(busy)
  );

  twi_seq #(.HALF_CYC(HALF_CYC)) u_seq (
    .clk(clk), .rst(rst), .go(ctrl_go), .busy(busy), .nack_ctl(ctrl_rxnak),
    .stall_en(ctrl_stall), .wr_go(wr_go), .wr_byte(reg_wdata),
    .scl_in(scl_in), .sda_in(sda_in),
    .scl_low(scl_drive_low), .sda_low(sda_drive_low),
    .ev_win(ev_win), .ev_err(ev_err), .ev_svc(ev_svc), .ev_nack(ev_nack),
    .ev_stall(ev_stall), .ev_rx_end(ev_rx_end), .rx_byte(rx_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_go <= 1'b0; ctrl_ien <= 1'b0; ctrl_rxnak <= 1'b0; ctrl_stall <= 1'b0;
    end else begin
      if (reg_we && sel_ctrl) begin
        ctrl_go    <= reg_wdata[0];
        ctrl_ien   <= reg_wdata[1];
        ctrl_rxnak <= reg_wdata[2];
        ctrl_stall <= reg_wdata[3];
      end
      if (ev_win || ev_err) ctrl_go <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= 1'b0; svc_q <= 1'b0; nack_q <= 1'b0; stl_q <= 1'b0;
      master_q <= 1'b0; addr_sent_q <= 1'b0; rx_q <= '0; irq <= 1'b0;
    end else begin
      err_q  <= (err_q & ~w1c[0]) | ev_err;
      svc_q  <= (svc_q & ~w1c[1] & ~wr_go & ~ev_err) | ev_svc;
      nack_q <= (nack_q & ~w1c[2]) | ev_nack;
      stl_q  <= (stl_q & ~w1c[3]) | ev_stall;
      if (ev_err) master_q <= 1'b0;
      else if (ev_win) master_q <= 1'b1;
      if (ev_err || ev_win) addr_sent_q <= 1'b0;
      else if (wr_go) addr_sent_q <= 1'b1;
      if (ev_rx_end) rx_q <= rx_byte;
      irq <= ctrl_ien & (err_q | svc_q | nack_q | stl_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (sel_ctrl) reg_rdata <= {4'b0000, ctrl_stall, ctrl_rxnak, ctrl_ien, ctrl_go};
    else if (sel_stat) reg_rdata <= {2'b00, busy, master_q, stl_q, nack_q, svc_q, err_q};
    else if (sel_data) reg_rdata <= rx_q;
    else reg_rdata <= '0;
  end

  p_acq_free_r1: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_drive_low) && !master_q) |-> !$past(busy));
  p_go_clear_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(master_q) |-> !ctrl_go);
  p_svc_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (master_q && svc_q) |-> scl_drive_low);
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (master_q && stl_q) |-> scl_drive_low);
  p_err_drop_r6: assert property (@(posedge clk) disable iff (rst)
    ev_err |=> (!master_q && !scl_drive_low && !sda_drive_low));
  p_irq_off_r10: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_ien && $past(!ctrl_ien)) |-> !irq);
  p_w1c_r11: assert property (@(posedge clk) disable iff (rst)
    (reg_we && sel_stat && reg_wdata[0] && !ev_err) |=> !err_q);
endmodule

// File: tb/twi_master_ctl_test.sv
`timescale 1ns/1ps
module twi_master_ctl_test;
  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] reg_addr = '0;
  logic reg_we = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic irq, scl_dl, sda_dl, scl_in, sda_in;
  logic ext_scl = 1'b0, ext_sda = 1'b0, sl_sda = 1'b0;
  logic sl_on = 1'b0, sl_ack = 1'b0, sl_rd = 1'b0, got_mack = 1'b0;
  logic [7:0] sl_tx = '0, got_addr = '0;
  int fc = 0, rises = 0, checks = 0, failures = 0, cyc = 0;

  always #10 clk = ~clk;

  assign scl_in = !(scl_dl | ext_scl);
  assign sda_in = !(sda_dl | ext_sda | sl_sda);

  twi_master_ctl #(.HALF_CYC(4), .AW(2)) uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_in(scl_in), .sda_in(sda_in),
    .scl_drive_low(scl_dl), .sda_drive_low(sda_dl)
  );

  // target model: counts SCL edges from the first address bit
  always @(negedge scl_in) if (sl_on) begin
    fc = fc + 1;
    if (fc == 8) sl_sda = sl_ack;
    else if (fc >= 9 && fc <= 16 && sl_rd) sl_sda = !sl_tx[16 - fc];
    else sl_sda = 1'b0;
  end

  always @(posedge scl_in) if (sl_on) begin
    rises = rises + 1;
    if (rises <= 8) got_addr = {got_addr[6:0], sda_in};
    if (rises == 18) got_mack = sda_in;
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired act=%0d exp=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      failures = failures + 1;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic poll(input logic [1:0] a, input logic [7:0] mask, output logic [7:0] d);
    d = '0;
    for (int i = 0; i < 3000; i++) begin
      rd(a, d);
      if ((d & mask) != 0) break;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; sl_on = 1'b0; sl_sda = 1'b0; ext_scl = 1'b0; ext_sda = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_case(input logic [7:0] addr, input logic ack, input logic stl,
                          input logic nk, input logic ien);
    logic [7:0] v, c;
    logic rdx;
    do_reset();
    wr(2'd0, {4'b0000, stl, nk, ien, 1'b1});
    poll(2'd1, 8'h10, v);
    chk("R2 master after start", v[4], 1);
    chk("R2 service after start", v[1], 1);
    chk("R2 scl held", scl_dl, 1);
    rd(2'd0, c);
    chk("R2 start bit cleared", c[0], 0);
    rdx = addr[0] & ack & !stl;
    sl_tx = 8'(addr * 3 + 8'h11);
    fc = 0; rises = 0; sl_ack = ack; sl_rd = rdx; sl_on = 1'b1;
    wr(2'd2, addr);
    poll(2'd1, 8'h0F, v);
    chk("R4 address bits", got_addr, addr);
    chk("R5 nack flag", v[2], !ack);
    chk("R7 stall flag", v[3], ack & stl);
    chk("R8 R9 service flag", v[1], ack & !stl);
    chk("R6 no error", v[0], 0);
    chk("R2 still master", v[4], 1);
    chk("R8 scl held", scl_dl, 1);
    if (rdx) begin
      rd(2'd2, c);
      chk("R9 received byte", c, sl_tx);
      chk("R9 master ack bit", got_mack, nk);
    end
    chk("R10 irq", irq, ien);
    wr(2'd2, 8'hA5);
    repeat (30) @(negedge clk);
    chk("R12 second write ignored", rises, rdx ? 18 : 9);
    chk("R7 scl still low", scl_dl, 1);
    wr(2'd1, 8'h0F);
    rd(2'd1, v);
    chk("R11 flags cleared", v & 8'h0F, 0);
    chk("R10 irq dropped", irq, 0);
  endtask

  initial begin
    logic [7:0] v;
    do_reset();
    rd(2'd1, v);
    chk("reset status", v, 0);
    chk("reset scl", scl_dl, 0);
    chk("reset sda", sda_dl, 0);
    chk("reset irq", irq, 0);

    // R1: another device makes a start, then a stop
    ext_sda = 1'b1;
    repeat (3) @(negedge clk);
    rd(2'd1, v);
    chk("R1 busy after foreign start", v[5], 1);
    wr(2'd0, 8'h01);
    repeat (20) @(negedge clk);
    chk("R1 no drive while busy", sda_dl, 0);
    rd(2'd1, v);
    chk("R1 no master while busy", v[4], 0);
    ext_sda = 1'b0;
    poll(2'd1, 8'h10, v);
    chk("R1 master after stop", v[4], 1);
    chk("R1 busy by own start", v[5], 1);

    // R3: SCL already low at acquisition
    do_reset();
    ext_scl = 1'b1;
    wr(2'd0, 8'h03);
    repeat (10) @(negedge clk);
    rd(2'd1, v);
    chk("R3 bus error", v[0], 1);
    chk("R3 not master", v[4], 0);
    chk("R3 sda released", sda_dl, 0);
    chk("R10 irq on error", irq, 1);
    ext_scl = 1'b0;

    // R6: SDA held low while an address 1 bit is sent
    do_reset();
    wr(2'd0, 8'h01);
    poll(2'd1, 8'h10, v);
    ext_sda = 1'b1;
    wr(2'd2, 8'hC2);
    poll(2'd1, 8'h01, v);
    chk("R6 sda conflict error", v[0], 1);
    chk("R6 sda conflict master cleared", v[4], 0);
    chk("R6 scl released", scl_dl, 0);
    chk("R6 sda released", sda_dl, 0);
    ext_sda = 1'b0;

    // R6: SCL pulled low during a high phase
    do_reset();
    wr(2'd0, 8'h01);
    poll(2'd1, 8'h10, v);
    wr(2'd2, 8'h40);
    @(posedge scl_in);
    ext_scl = 1'b1;
    poll(2'd1, 8'h01, v);
    chk("R6 scl conflict error", v[0], 1);
    chk("R6 scl conflict master cleared", v[4], 0);
    chk("R6 scl conflict lines free", {scl_dl, sda_dl}, 0);
    ext_scl = 1'b0;

    // R12: data write while idle
    do_reset();
    wr(2'd2, 8'h55);
    repeat (30) @(negedge clk);
    chk("R12 idle write no scl", scl_dl, 0);
    chk("R12 idle write no sda", sda_dl, 0);
    rd(2'd1, v);
    chk("R12 idle write status", v, 0);

    // sweep over address pattern, ack, stall mode, reply-NACK
    for (int a = 0; a < 8; a++)
      for (int k = 0; k < 2; k++)
        for (int s = 0; s < 2; s++)
          for (int n = 0; n < 2; n++)
            run_case(8'(a * 8'h35 + 8'h1A), k[0], s[0], n[0], a[1]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule